// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one output cell of a small programmable logic array. The array itself, which is outside the block, produces a set of data product terms and four control terms for each cell. The cell ORs the data terms into a sum. It then presents that sum on its pin either directly (combinatorial mode) or through a state bit. The state bit is clocked by a logic term rather than by a global clock. Set and clear terms can force the state bit at any time. A static polarity bit and a static output-enable mode shape what reaches the pin. The cell also returns a feedback value to the array.

The cell is modelled for a synchronous fabric. A free-running sampling clock `clk` samples all inputs. The rising edge of the clock term is found by comparing each sample with the one before it. Set, clear and preload act on the next `clk` edge whatever the clock term is doing, so they behave asynchronously with respect to that term. Driving `preload_n` low forces the state bit to the value on the pin input, which lets a test load any state, including one the logic could never reach. The synchronous reset `rst` stands in for power-up and clears the state bit.

Top module: `plc_macrocell`

## Requirements
- R1: The data sum is the OR of all `pt_data` bits. It is the value a clock-term edge loads and the value a combinatorial cell drives.
- R2: With preload, set and clear all inactive, the state bit takes the data sum on a `clk` edge where `pt_clk` is 1 and was 0 at the previous `clk` edge. A `pt_clk` held high loads nothing more.
- R3: With preload inactive, `pt_set` alone forces the state bit to 1 and `pt_clr` alone forces it to 0 at the next `clk` edge. Either one overrides a clock-term edge.
- R4: When `pt_set` and `pt_clr` are both 1, the output level is the data sum, with no cycle of delay. In this mode, each `clk` edge without preload also loads the sum into the state bit.
- R5: `pin_out` equals the output level when `cfg_pol` is 1 and its inverse when `cfg_pol` is 0. The output level is the state bit, or the data sum in the mode of R4.
- R6: `pin_oe` depends on `cfg_oe_mode`: code 0 gives 1; code 1 gives NOT `oe_pin_n`; code 2 gives `pt_oe`; code 3 gives `pt_oe` AND NOT `oe_pin_n`.
- R7: When `preload_n` is 0 at a `clk` edge, the state bit takes `pin_in`. This overrides set, clear and the clock term.
- R8: `rst` high at a `clk` edge clears the state bit. With `cfg_pol` at 0 and the cell not combinatorial, `pin_out` then reads 1.
- R9: `fb` equals `pin_out` while `pin_oe` is 1 and `pin_in` while `pin_oe` is 0.
- R10: With no reset, no preload, no set or clear, and no clock-term rising edge, the state bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock of the fabric |
| rst | input | 1 | synchronous active-high power-up clear |
| pt_data | input | N_DATA | data product terms |
| pt_clk | input | 1 | clock product term for the state bit |
| pt_set | input | 1 | set product term |
| pt_clr | input | 1 | clear product term |
| pt_oe | input | 1 | output-enable product term |
| oe_pin_n | input | 1 | shared active-low output-enable pin |
| preload_n | input | 1 | shared active-low preload strobe |
| pin_in | input | 1 | value seen on the cell's pin |
| cfg_pol | input | 1 | 1 = active-high output, 0 = inverted |
| cfg_oe_mode | input | 2 | enable source code, see R6 |
| pin_out | output | 1 | value driven toward the pin |
| pin_oe | output | 1 | pin driver enable |
| fb | output | 1 | feedback value to the array |

## Verification
The properties assume that the configuration inputs change only between cycles, and that every control term is a clean level at each `clk` edge. A rising edge of the clock term can therefore only be seen as a 0 sample followed by a 1 sample. The bench changes every input on the falling edge of `clk`, so each input is a stable level at the next rising edge. It draws set, clear and preload with low probability so that long runs of clock-term loads and holds occur, and it exercises every polarity and enable code.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    OE_ALWAYS = 2'd0,
    OE_PIN    = 2'd1,
    OE_TERM   = 2'd2,
    OE_BOTH   = 2'd3
  } oe_mode_t;
endpackage

// File: rtl/plc_sum.sv
module plc_sum #(
  parameter int N_DATA = 4
) (
  input  logic [N_DATA-1:0] terms,
  output logic              sum
);
  logic [N_DATA:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_DATA; i++) begin : g_or
    assign chain[i+1] = chain[i] | terms[i];
  end
  assign sum = chain[N_DATA];
endmodule

// File: rtl/plc_state.sv
module plc_state (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic ck_term,
  input  logic set_t,
  input  logic clr_t,
  input  logic preload_n,
  input  logic pin_in,
  output logic q
);
  logic ck_prev;
  logic ck_rise;
  assign ck_rise = ck_term & ~ck_prev;

  always_ff @(posedge clk) begin
    ck_prev <= ck_term;
    if (rst)                q <= 1'b0;
    else if (!preload_n)    q <= pin_in;
    else if (set_t & clr_t) q <= d;
    else if (set_t)         q <= 1'b1;
    else if (clr_t)         q <= 1'b0;
    else if (ck_rise)       q <= d;
  end
endmodule

// File: rtl/plc_oe.sv
module plc_oe
  import plc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       term,
  input  logic       pin_n,
  output logic       oe
);
  oe_mode_t m;
  assign m = oe_mode_t'(mode);
  always_comb begin
    unique case (m)
      OE_ALWAYS: oe = 1'b1;
      OE_PIN:    oe = ~pin_n;
      OE_TERM:   oe = term;
      OE_BOTH:   oe = term & ~pin_n;
      default:   oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell #(
  parameter int N_DATA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DATA-1:0] pt_data,
  input  logic              pt_clk,
  input  logic              pt_set,
  input  logic              pt_clr,
  input  logic              pt_oe,
  input  logic              oe_pin_n,
  input  logic              preload_n,
  input  logic              pin_in,
  input  logic              cfg_pol,
  input  logic [1:0]        cfg_oe_mode,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb
);
  logic dsum;
  logic q_state;
  logic comb_mode;
  logic level;

  plc_sum #(.N_DATA(N_DATA)) u_sum (.terms(pt_data), .sum(dsum));

  plc_state u_state (
    .clk(clk), .rst(rst), .d(dsum), .ck_term(pt_clk),
    .set_t(pt_set), .clr_t(pt_clr), .preload_n(preload_n),
    .pin_in(pin_in), .q(q_state)
  );

  plc_oe u_oe (.mode(cfg_oe_mode), .term(pt_oe), .pin_n(oe_pin_n), .oe(pin_oe));

  assign comb_mode = pt_set & pt_clr;
  assign level     = comb_mode ? dsum : q_state;
  assign pin_out   = cfg_pol ? level : ~level;
  assign fb        = pin_oe ? pin_out : pin_in;
endmodule

// File: rtl/plc_macrocell_chk.sv
module plc_macrocell_chk #(
  parameter int N_DATA = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_DATA-1:0] pt_data,
  input logic              pt_clk,
  input logic              pt_set,
  input logic              pt_clr,
  input logic              oe_pin_n,
  input logic              preload_n,
  input logic              pin_in,
  input logic              cfg_pol,
  input logic [1:0]        cfg_oe_mode,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              fb,
  input logic              q
);
  AST_PWRUP_CLEAR: assert property (@(posedge clk) rst |=> !q); // R8
  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    !preload_n |=> q == $past(pin_in)); // R7
  AST_SET_FORCE: assert property (@(posedge clk) disable iff (rst)
    (preload_n && pt_set && !pt_clr) |=> q); // R3
  AST_CLR_FORCE: assert property (@(posedge clk) disable iff (rst)
    (preload_n && pt_clr && !pt_set) |=> !q); // R3
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    (preload_n && !pt_set && !pt_clr && !(pt_clk && !$past(pt_clk))) |=> $stable(q)); // R10
  AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (preload_n && !pt_set && !pt_clr && pt_clk && !$past(pt_clk)) |=> q == $past(|pt_data)); // R2
  AST_COMB_PATH: assert property (@(posedge clk) disable iff (rst)
    (pt_set && pt_clr) |-> (pin_out ^ !cfg_pol) == (|pt_data)); // R4
  AST_FB_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> fb == pin_out); // R9
  AST_FB_INPUT: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> fb == pin_in); // R9
  AST_PIN_DISABLE: assert property (@(posedge clk) disable iff (rst)
    (oe_pin_n && cfg_oe_mode[0]) |-> !pin_oe); // R6
endmodule

bind plc_macrocell plc_macrocell_chk #(.N_DATA(N_DATA)) u_chk (
  .clk(clk), .rst(rst), .pt_data(pt_data), .pt_clk(pt_clk), .pt_set(pt_set),
  .pt_clr(pt_clr), .oe_pin_n(oe_pin_n), .preload_n(preload_n), .pin_in(pin_in),
  .cfg_pol(cfg_pol), .cfg_oe_mode(cfg_oe_mode), .pin_out(pin_out),
  .pin_oe(pin_oe), .fb(fb), .q(q_state)
);

// File: tb/sim_plc_macrocell.sv
module sim_plc_macrocell;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] pt_data;
  logic pt_clk, pt_set, pt_clr, pt_oe, oe_pin_n, preload_n, pin_in, cfg_pol;
  logic [1:0] cfg_oe_mode;
  logic pin_out, pin_oe, fb;
  int n_run = 0;
  int n_fail = 0;
  logic q_m, prev_m;

  always #4 clk = ~clk;

  plc_macrocell #(.N_DATA(N)) u0 (
    .clk(clk), .rst(rst), .pt_data(pt_data), .pt_clk(pt_clk), .pt_set(pt_set),
    .pt_clr(pt_clr), .pt_oe(pt_oe), .oe_pin_n(oe_pin_n), .preload_n(preload_n),
    .pin_in(pin_in), .cfg_pol(cfg_pol), .cfg_oe_mode(cfg_oe_mode),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic logic exp_level();
    return (pt_set && pt_clr) ? |pt_data : q_m;
  endfunction
  function automatic logic exp_out();
    return cfg_pol ? exp_level() : ~exp_level();
  endfunction
  function automatic logic exp_oe();
    case (cfg_oe_mode)
      2'd0: return 1'b1;
      2'd1: return ~oe_pin_n;
      2'd2: return pt_oe;
      default: return pt_oe & ~oe_pin_n;
    endcase
  endfunction
  function automatic logic exp_fb();
    return exp_oe() ? exp_out() : pin_in;
  endfunction

  task automatic model_edge();
    if (rst) q_m = 1'b0;
    else if (!preload_n) q_m = pin_in;
    else if (pt_set && pt_clr) q_m = |pt_data;
    else if (pt_set) q_m = 1'b1;
    else if (pt_clr) q_m = 1'b0;
    else if (pt_clk && !prev_m) q_m = |pt_data;
    prev_m = pt_clk;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, pin_out, exp_out());
    chk("R6", pin_oe, exp_oe());
    chk("R9", fb, exp_fb());
  endtask

  task automatic cycle(input string tag);
    #1 chk_all(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic drive(input logic [N-1:0] d, input logic ck, input logic s,
                       input logic c, input logic pl_n, input logic pi);
    pt_data = d; pt_clk = ck; pt_set = s; pt_clr = c; preload_n = pl_n; pin_in = pi;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20240611);
    rst = 1'b1; pt_oe = 1'b0; oe_pin_n = 1'b0; cfg_pol = 1'b0; cfg_oe_mode = 2'd0;
    drive('0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    q_m = 1'b0; prev_m = 1'b0;
    repeat (3) begin @(posedge clk); model_edge(); end
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R8 reset inverted output", pin_out, 1'b1);
    cfg_pol = 1'b1;
    #1 chk("R8 reset state", pin_out, 1'b0);
    // R7: preload beats a clear term
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    cycle("R7");
    chk("R7 preload over clear", pin_out, 1'b1);
    // R10: nothing active, data and pin change, state holds
    drive(4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R10");
    chk("R10 hold", pin_out, 1'b1);
    // R2: rising clock term with zero sum
    drive(4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R2");
    chk("R2 edge load 0", pin_out, 1'b0);
    drive(4'b0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R2");
    chk("R2 high level no load", pin_out, 1'b0);
    drive(4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R10");
    drive(4'b0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R1");
    chk("R1 single term sum", pin_out, 1'b1);
    // R3: clear overrides an edge with sum 1
    drive(4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cycle("R10");
    drive(4'b1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    cycle("R3");
    chk("R3 clear over edge", pin_out, 1'b0);
    drive(4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    cycle("R3");
    chk("R3 set", pin_out, 1'b1);
    // R4: combinatorial path, immediate
    drive(4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    #1 chk("R4 comb zero", pin_out, 1'b0);
    cycle("R4");
    pt_data = 4'b0010;
    #1 chk("R4 comb one", pin_out, 1'b1);
    cfg_pol = 1'b0;
    #1 chk("R5 inverted comb", pin_out, 1'b0);
    cycle("R4");
    // R6 / R9: pin disables, fb follows pin_in
    cfg_oe_mode = 2'd1; oe_pin_n = 1'b1; pin_in = 1'b1;
    #1 chk("R6 pin disable", pin_oe, 1'b0);
    chk("R9 fb input", fb, 1'b1);
    cfg_oe_mode = 2'd2; pt_oe = 1'b1;
    #1 chk("R6 term only", pin_oe, 1'b1);
    cycle("R5");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom();
      pt_data = r[3:0];
      pt_clk = r[4];
      pt_set = (r[7:5] == 3'd0);
      pt_clr = (r[10:8] == 3'd0);
      preload_n = (r[14:11] != 4'd0);
      pin_in = r[15];
      pt_oe = r[16];
      oe_pin_n = r[17];
      if (r[23:20] == 4'd0) begin
        cfg_pol = r[18];
        cfg_oe_mode = r[25:24];
      end
      rst = (r[31:26] == 6'd0);
      if (rst) begin
        @(posedge clk); model_edge(); @(negedge clk);
        rst = 1'b0;
      end else begin
        cycle("R5");
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule